// File: doc/BRIEF.md
# Page-Mode Burst Bus Slave Responder

This block answers accesses on a multiplexed 32-bit expansion bus. When the master raises the full-cycle strobe, the address lines are captured. If the top address bits match the configured base, the slave select is raised. From then on the captured upper address, down to the 256-byte page boundary, is held for the rest of the cycle. The first transfer uses the word offset carried in the address phase. Each later short cycle supplies only a fresh six-bit word offset and read/write level, and the block joins that offset to the held page.

Every transfer is turned into one request on a local word port. That port may stall. The block answers the master with a data acknowledge once the local side is ready. A burst-capable build advertises that it can take more transfers by holding a burst acknowledge. It drops that acknowledge one transfer early, either because a parameter limit is close or because the local side says it can only take one more. This lets the master end the burst cleanly.

All bus-side signals are active high in this block; level translation to the bus's inverted lines lies outside it.

Top module: `pbs_top`

## Requirements
- R1: After reset, sel_o, burst_ack_o, data_ack_o, rd_oe_o and mem_req_o are all low.
- R2: With the block idle, a high full_strobe_i samples ad_i. If ad_i[31:24] equals BASE, sel_o is high from the next cycle. Otherwise sel_o stays low, and no memory request or data acknowledge occurs until full_strobe_i falls.
- R3: A build with MAX_BURST of two or more raises burst_ack_o together with sel_o.
- R4: In the first data phase, out_en_i high with any byte_strb_i bit set starts a memory request on the next cycle. The request uses mem_addr_o = {ad_i[31:8] from the address phase, ad_i[7:2] from the address phase}, mem_be_o = byte_strb_i, mem_we_o = not rd_i, and mem_wdata_o = ad_i, all sampled in the strobe cycle.
- R5: mem_req_o stays high with a stable address and enables until mem_ready_i is high. data_ack_o rises in the cycle after that. In the same cycle rd_data_o holds the mem_rdata_i value sampled with ready, and rd_oe_o is high for a read and low for a write.
- R6: data_ack_o stays high while any byte_strb_i bit is set, and falls in the cycle after all strobes are low.
- R7: After a transfer, while full_strobe_i stays high, burst_req_i high together with out_en_i and a set strobe starts a short cycle. Its word address is {held page, lo_addr_i}, and it takes rd_i, byte_strb_i and ad_i as in R4.
- R8: Transfers are counted from 0 for the full-cycle transfer. burst_ack_o falls in the cycle after transfer MAX_BURST-2 begins. Transfer MAX_BURST-1 is still served, and any short-cycle request after it is ignored.
- R9: mem_last_i high during a selected cycle drops burst_ack_o on the next cycle, and it stays low until the cycle ends. One further short cycle is served, and any request after that one is ignored.
- R10: The cycle after full_strobe_i is sampled low, sel_o, burst_ack_o, data_ack_o, rd_oe_o and mem_req_o are all low, even in the middle of a transfer.
- R11: Within one selected cycle, burst_ack_o never rises again once it has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_strobe_i | input | 1 | Full-cycle strobe from master |
| burst_req_i | input | 1 | Multi-transfer request / short-cycle start |
| rd_i | input | 1 | High for read, low for write |
| out_en_i | input | 1 | Data-phase output enable from master |
| byte_strb_i | input | 4 | Byte data strobes |
| ad_i | input | 32 | Multiplexed address / write data |
| lo_addr_i | input | 6 | Word offset inside the page for short cycles |
| mem_last_i | input | 1 | Local side can take only one more transfer |
| mem_rdata_i | input | 32 | Local read data |
| mem_ready_i | input | 1 | Local port completes the request |
| sel_o | output | 1 | Slave select |
| burst_ack_o | output | 1 | Multi-transfer acknowledge |
| data_ack_o | output | 1 | Data acknowledge |
| rd_data_o | output | 32 | Read data to bus |
| rd_oe_o | output | 1 | Read data valid on rd_data_o |
| mem_req_o | output | 1 | Local request |
| mem_we_o | output | 1 | Local write enable |
| mem_addr_o | output | 30 | Local word address |
| mem_be_o | output | 4 | Local byte enables |
| mem_wdata_o | output | 32 | Local write data |

## Verification
The bench builds the block with BASE 8'hC3 and MAX_BURST 4. With a limit that small, the automatic withdrawal, the last served transfer and the refused fifth request all fall within a single four-transfer burst. The nonzero base lets a miss be formed by changing only the top address byte. Local stalls of zero to three cycles are applied so that the request-hold and acknowledge latency are seen with and without wait states. A separate burst drives the local withdrawal input.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MISS,
    ST_DPH,
    ST_MEM,
    ST_ACK,
    ST_GAP
  } pbs_state_e;
endpackage

// File: rtl/pbs_addr_match.sv
module pbs_addr_match #(
  parameter int          BASE_W = 8,
  parameter logic [BASE_W-1:0] BASE = '0
) (
  input  logic [BASE_W-1:0] hi_i,
  output logic              hit_o
);
  assign hit_o = (hi_i == BASE);
endmodule

// File: rtl/pbs_burst_limit.sv
module pbs_burst_limit #(
  parameter int MAX_BURST = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic active_i,
  input  logic start_i,
  input  logic stop_req_i,
  output logic ack_o,
  output logic more_ok_o
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);
  localparam bit CAPABLE = (MAX_BURST > 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stop_q;
  logic             more_q;

  // ack falls once transfer MAX_BURST-2 has started
  assign ack_o     = CAPABLE && active_i && !stop_q && (32'(cnt_q) < MAX_BURST - 1);
  assign more_ok_o = more_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
      more_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
      more_q <= 1'b0;
    end else begin
      if (start_i) begin
        more_q <= ack_o;  // what the master sees at this transfer's start
        if (32'(cnt_q) < MAX_BURST) cnt_q <= cnt_q + 1'b1;
      end
      if (stop_req_i && active_i) stop_q <= 1'b1;
    end
  end

  p_ack_no_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !ack_o) |=> !ack_o);

  p_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (32'(cnt_q) < MAX_BURST));
endmodule

// File: rtl/pbs_top.sv
module pbs_top
  import pbs_pkg::*;
#(
  parameter int                BUS_W     = 32,
  parameter int                PAGE_LSB  = 8,
  parameter int                BASE_W    = 8,
  parameter logic [BASE_W-1:0] BASE      = 8'hC3,
  parameter int                MAX_BURST = 8,
  localparam int               BE_W      = BUS_W / 8,
  localparam int               LO_W      = PAGE_LSB - 2,
  localparam int               WORD_W    = BUS_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_strobe_i,
  input  logic              burst_req_i,
  input  logic              rd_i,
  input  logic              out_en_i,
  input  logic [BE_W-1:0]   byte_strb_i,
  input  logic [BUS_W-1:0]  ad_i,
  input  logic [LO_W-1:0]   lo_addr_i,
  input  logic              mem_last_i,
  input  logic [BUS_W-1:0]  mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              sel_o,
  output logic              burst_ack_o,
  output logic              data_ack_o,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              rd_oe_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [BUS_W-1:0]  mem_wdata_o
);
  localparam int PAGE_W = BUS_W - PAGE_LSB;

  pbs_state_e         st_q;
  logic [PAGE_W-1:0]  page_q;
  logic [LO_W-1:0]    lo_q;
  logic               we_q;
  logic [BE_W-1:0]    be_q;
  logic [BUS_W-1:0]   wdata_q;
  logic [BUS_W-1:0]   rdata_q;

  logic hit, ds_go, short_go, xfer_start, more_ok;

  pbs_addr_match #(.BASE_W(BASE_W), .BASE(BASE)) u_match (
    .hi_i  (ad_i[BUS_W-1 -: BASE_W]),
    .hit_o (hit)
  );

  assign sel_o    = (st_q != ST_IDLE) && (st_q != ST_MISS);
  assign ds_go    = out_en_i && (|byte_strb_i);
  assign short_go = ds_go && burst_req_i && more_ok;
  assign xfer_start = full_strobe_i &&
                      (((st_q == ST_DPH) && ds_go) || ((st_q == ST_GAP) && short_go));

  pbs_burst_limit #(.MAX_BURST(MAX_BURST)) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (st_q == ST_IDLE),
    .active_i   (sel_o),
    .start_i    (xfer_start),
    .stop_req_i (mem_last_i),
    .ack_o      (burst_ack_o),
    .more_ok_o  (more_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      page_q  <= '0;
      lo_q    <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (full_strobe_i) begin
        page_q <= ad_i[BUS_W-1:PAGE_LSB];
        lo_q   <= ad_i[PAGE_LSB-1:2];
        st_q   <= hit ? ST_DPH : ST_MISS;
      end
    end else if (!full_strobe_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_DPH: if (ds_go) begin
          be_q    <= byte_strb_i;
          we_q    <= !rd_i;
          wdata_q <= ad_i;
          st_q    <= ST_MEM;
        end
        ST_MEM: if (mem_ready_i) begin
          rdata_q <= mem_rdata_i;
          st_q    <= ST_ACK;
        end
        ST_ACK: if (byte_strb_i == '0) st_q <= ST_GAP;
        ST_GAP: if (short_go) begin
          lo_q    <= lo_addr_i;
          be_q    <= byte_strb_i;
          we_q    <= !rd_i;
          wdata_q <= ad_i;
          st_q    <= ST_MEM;
        end
        default: ;
      endcase
    end
  end

  assign data_ack_o  = (st_q == ST_ACK);
  assign rd_oe_o     = (st_q == ST_ACK) && !we_q;
  assign rd_data_o   = rdata_q;
  assign mem_req_o   = (st_q == ST_MEM);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = {page_q, lo_q};
  assign mem_be_o    = be_q;
  assign mem_wdata_o = wdata_q;

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_strobe_i |=> (!sel_o && !data_ack_o && !burst_ack_o && !mem_req_o));

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && full_strobe_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)));

  p_ack_after_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_ack_o) |-> $past(mem_req_o && mem_ready_i));

  p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ack_o && (|byte_strb_i) && full_strobe_i) |=> data_ack_o);

  p_unselected_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> (!mem_req_o && !data_ack_o && !burst_ack_o));
endmodule

// File: tb/pbs_top_test.sv
module pbs_top_test;
  localparam int MB = 4;
  localparam logic [7:0] BASE = 8'hC3;

  typedef struct packed {
    logic [29:0] addr;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wdata;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic full = 0, breq = 0, rd = 0, oe = 0, mlast = 0, mready = 0;
  logic [3:0] strb = '0;
  logic [31:0] ad = '0, mrdata = '0;
  logic [5:0] lo = '0;
  logic sel, back, dack, rdoe, mreq, mwe;
  logic [31:0] rdat, mwdata;
  logic [29:0] maddr;
  logic [3:0] mbe;

  int n_chk = 0, n_bad = 0, stall_cfg = 0, wcnt = 0;
  item_t q[$];
  logic [23:0] page;

  always #2 clk = ~clk;

  pbs_top #(.BASE(BASE), .MAX_BURST(MB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .full_strobe_i(full), .burst_req_i(breq),
    .rd_i(rd), .out_en_i(oe), .byte_strb_i(strb), .ad_i(ad), .lo_addr_i(lo),
    .mem_last_i(mlast), .mem_rdata_i(mrdata), .mem_ready_i(mready),
    .sel_o(sel), .burst_ack_o(back), .data_ack_o(dack), .rd_data_o(rdat),
    .rd_oe_o(rdoe), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_be_o(mbe), .mem_wdata_o(mwdata));

  function automatic logic [31:0] pat(input logic [29:0] a);
    return {a, 2'b11} ^ 32'hA5A5_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // local memory model + scoreboard monitor
  always @(negedge clk) begin
    mready = 1'b0;
    if (mreq) begin
      if (q.size() == 0) begin
        check(0, "R4 unexpected request", {34'b0, maddr}, 64'h0);
      end else if (wcnt == stall_cfg) begin
        check({maddr, mwe, mbe} == {q[0].addr, q[0].we, q[0].be}, "R4/R7 request",
              {29'b0, maddr, mwe, mbe}, {29'b0, q[0].addr, q[0].we, q[0].be});
        if (q[0].we) check(mwdata == q[0].wdata, "R4 wdata", {32'b0, mwdata}, {32'b0, q[0].wdata});
        mrdata = pat(maddr);
        mready = 1'b1;
        void'(q.pop_front());
        wcnt = 0;
      end else begin
        check(maddr == q[0].addr && mbe == q[0].be, "R5 stall hold",
              {34'b0, maddr}, {34'b0, q[0].addr});
        wcnt++;
      end
    end else wcnt = 0;
  end

  task automatic start_cycle(input logic [31:0] a, input bit exp_hit);
    @(negedge clk);
    full = 1; ad = a; oe = 0; strb = '0; breq = 0;
    page = a[31:8];
    @(negedge clk);
    check(sel == exp_hit, "R2 select", {63'b0, sel}, {63'b0, exp_hit});
    check(back == exp_hit, "R3 burst ack with select", {63'b0, back}, {63'b0, exp_hit});
  endtask

  task automatic xfer(input bit first, input logic [5:0] lw, input bit r, input logic [3:0] be,
                      input logic [31:0] wd, input int stall, input bit exp_back, input bit release_it);
    item_t it;
    int n;
    it.addr = {page, lw}; it.we = !r; it.be = be; it.wdata = wd;
    stall_cfg = stall;
    q.push_back(it);
    oe = 1; strb = be; rd = r; ad = r ? 32'h0 : wd;
    if (!first) begin breq = 1; lo = lw; end
    n = 0;
    do begin @(negedge clk); n++; end while (!dack && n < 40);
    check(dack, "R5 data ack seen", {63'b0, dack}, 64'h1);
    check(n == stall + 2, "R5 ack latency", n, stall + 2);
    check(rdoe == r, "R5 read enable", {63'b0, rdoe}, {63'b0, r});
    if (r) check(rdat == pat(it.addr), "R5 read data", {32'b0, rdat}, {32'b0, pat(it.addr)});
    check(back == exp_back, "R8/R9 burst ack level", {63'b0, back}, {63'b0, exp_back});
    if (release_it) begin
      @(negedge clk);
      check(dack, "R6 ack held with strobes", {63'b0, dack}, 64'h1);
      strb = '0; breq = 0;
      @(negedge clk);
      check(!dack, "R6 ack drops after strobes", {63'b0, dack}, 64'h0);
    end
  endtask

  task automatic ignored_req(input string req);
    breq = 1; oe = 1; strb = 4'hF; lo = 6'h2A; rd = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!mreq && !dack, req, {62'b0, mreq, dack}, 64'h0);
    end
    breq = 0; strb = '0;
    @(negedge clk);
  endtask

  task automatic end_cycle;
    full = 0; oe = 0; strb = '0; breq = 0;
    @(negedge clk);
    check(!sel && !back && !dack && !rdoe && !mreq, "R10 release",
          {59'b0, sel, back, dack, rdoe, mreq}, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!sel && !back && !dack && !rdoe && !mreq, "R1 reset state",
          {59'b0, sel, back, dack, rdoe, mreq}, 64'h0);

    // R2 miss: strobes ignored for the whole cycle
    start_cycle(32'h44_1234_10, 1'b0);
    oe = 1; strb = 4'hF; rd = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!sel && !mreq && !dack, "R2 miss stays quiet", {61'b0, sel, mreq, dack}, 64'h0);
    end
    end_cycle();

    // R3/R4/R7/R8: four-transfer burst hitting the limit
    start_cycle({BASE, 16'h1234, 8'h14}, 1'b1);
    xfer(1, 6'h05, 1'b0, 4'hF, 32'hDEAD_BEEF, 0, 1'b1, 1'b1);
    xfer(0, 6'h3F, 1'b1, 4'hF, 32'h0, 2, 1'b1, 1'b1);
    xfer(0, 6'h00, 1'b0, 4'h6, 32'h1357_9BDF, 1, 1'b0, 1'b1);  // R8 ack withdrawn here
    xfer(0, 6'h11, 1'b1, 4'h1, 32'h0, 3, 1'b0, 1'b1);          // R8 last served
    ignored_req("R8 request past limit ignored");
    check(q.size() == 0, "R8 scoreboard drained", q.size(), 0);
    end_cycle();

    // R9: local withdrawal
    start_cycle({BASE, 16'hABCD, 8'hFC}, 1'b1);
    xfer(1, 6'h3F, 1'b1, 4'hF, 32'h0, 0, 1'b1, 1'b1);
    mlast = 1;
    @(negedge clk);
    mlast = 0;
    check(!back && sel, "R9 ack dropped by local side", {62'b0, back, sel}, 64'h1);
    @(negedge clk);
    check(!back, "R11 ack stays low", {63'b0, back}, 64'h0);
    xfer(0, 6'h08, 1'b0, 4'hC, 32'hCAFE_F00D, 1, 1'b0, 1'b1);
    ignored_req("R9 request after withdrawal ignored");
    end_cycle();

    // R10: full strobe dropped while acknowledging a read
    start_cycle({BASE, 16'h0F0F, 8'h80}, 1'b1);
    xfer(1, 6'h20, 1'b1, 4'h3, 32'h0, 1, 1'b1, 1'b0);
    end_cycle();

    check(q.size() == 0, "R4 all requests seen", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule